// File: doc/BRIEF.md
# Hub Repeater Routing and Low-Speed Gating

This block is the routing and driver-enable core of a hub repeater. It has one upstream port and a set of downstream ports. It works on line states that are already decoded: each port presents its received D+/D- pair and receives a D+/D- pair to drive, together with a drive enable. Traffic that starts on the upstream side is repeated to every enabled full-speed downstream port. Low-speed ports receive traffic only after a preamble PID strobe has opened a low-speed window. Traffic that starts on a downstream port claims the upstream path and is repeated upward until that port ends its packet.

At attach, the block records the speed of each port from the line that is pulled high. From then on it applies the idle polarity that belongs to that speed, both when it interprets what the port sends and when it drives the port. A frame timer runs on a bit-rate tick and is cleared by an SOF strobe. It emits an end-of-frame marker pulse a fixed number of bit times before it wraps.

All outputs are registered. Each output reflects the inputs sampled at the previous clock edge.

Top module: `hub_repeater_core`

## Requirements
- R1: On a rising edge of `port_conn_i[p]`, `port_ls_o[p]` is loaded from the received pair of that port on the next clock: 1 when the pair reads D-/D+ = high/low (pair value 2'b01, bit 1 is D+), 0 when it reads 2'b10. At any other time the flag holds, whatever the line does.
- R2: While neither direction is busy, a K (2'b01) on `us_rx_i` starts a downstream packet. On the next clock every enabled full-speed port is driven with the upstream pair. Disabled ports are never driven.
- R3: A packet ends at the first J (2'b10) after an SE0 (2'b00). The ports stay driven for the cycle that carries that J and are released on the following cycle.
- R4: A port flagged low speed is not driven during a packet in which no preamble strobe has been seen.
- R5: A `pre_pid_i` strobe inside a downstream packet opens the low-speed window. Enabled low-speed ports are driven from the second clock after the strobe, which is well within four full-speed bit times. Full-speed ports keep receiving the same traffic. The window closes at the end of that packet's EOP.
- R6: A low-speed port is driven with D+ and D- swapped, and its received pair is interpreted swapped. A port that is not driven shows its own idle level: 2'b10 for full speed, 2'b01 for low speed. `us_tx_o` shows J when it is not driven.
- R7: While both directions are idle, the lowest-index enabled port whose interpreted state is K takes the upstream path. On the next clock `us_tx_o` carries that port's interpreted pair, `us_oe_o` is high and `owner_o` gives the index. Disabled ports cannot take the path.
- R8: The upstream path is released on the cycle after the owner's interpreted EOP (SE0 then J). The J cycle is still driven upward. `owner_o` holds the last owner, and another port may then take the path.
- R9: Only one direction is active at a time. When upstream K and a downstream K appear in the same idle cycle, the downstream packet wins. A start on the other side is ignored while a direction is busy.
- R10: `frame_cnt_o` advances by one on each clock with `bit_tick_i` high and holds otherwise. It wraps from FRAME_BITS-1 (11999) to 0.
- R11: `sof_pid_i` clears `frame_cnt_o` to 0 on the next clock, and it takes precedence over a tick in the same cycle.
- R12: `eof2_o` is high for exactly one clock, in the cycle in which `frame_cnt_o` first shows FRAME_BITS-EOF2_LEAD (11990).
- R13: After reset no driver is enabled, every pair output is at full-speed idle 2'b10, `owner_o` is 0, `port_ls_o` is 0 and `frame_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_rx_i | input | 2 | Upstream received pair {D+, D-} |
| us_tx_o | output | 2 | Upstream pair to drive {D+, D-} |
| us_oe_o | output | 1 | Upstream driver enable |
| dn_rx_i | input | 2*NPORT | Downstream received pairs, port p at bits 2p+1:2p |
| dn_tx_o | output | 2*NPORT | Downstream pairs to drive, port p at bits 2p+1:2p |
| dn_oe_o | output | NPORT | Downstream driver enables |
| port_en_i | input | NPORT | Port enabled by the hub controller |
| port_conn_i | input | NPORT | Port attach indication |
| pre_pid_i | input | 1 | Strobe: preamble PID last bit decoded |
| sof_pid_i | input | 1 | Strobe: SOF token decoded |
| bit_tick_i | input | 1 | One pulse per full-speed bit time |
| port_ls_o | output | NPORT | Port speed flag, 1 = low speed |
| owner_o | output | OWN_W | Index of the port holding the upstream path |
| frame_cnt_o | output | CNT_W | Frame timer value |
| eof2_o | output | 1 | End-of-frame marker pulse |

## Verification
The bench targets the edges of the low-speed window. It checks that the window does not open before the strobe, that it drives the low-speed port through the last J of the EOP, and that it closes at once for the packet that follows. A design that ended the window one cycle early or late, or kept it open, would mismatch on the low-speed port's enable. The bench also starts two upstream claims in the same cycle, one of them on a low-speed port that shows K only once the swap is applied. A wrong priority, a missing polarity swap or a late release would show the wrong owner or pair on the upstream output. Finally, it runs the frame timer across the marker and the wrap, and it places an SOF on a tick cycle to catch off-by-one counting and a tick that wins over the clear.

// File: rtl/hubrep_pkg.sv
// Shared line-state encoding and helpers for the hub repeater core.
// A pair is {D+, D-}. Logical states use full-speed polarity.
package hubrep_pkg;
    typedef logic [1:0] pair_t;

    localparam pair_t PAIR_SE0 = 2'b00;
    localparam pair_t PAIR_J   = 2'b10;
    localparam pair_t PAIR_K   = 2'b01;

    // Converts between wire and logical polarity; the swap is its own inverse.
    function automatic pair_t to_logical(input pair_t w, input logic ls);
        return ls ? {w[0], w[1]} : w;
    endfunction

    // Idle (J) level on the wire for a port of the given speed.
    function automatic pair_t idle_of(input logic ls);
        return ls ? 2'b01 : 2'b10;
    endfunction
endpackage

// File: rtl/hubrep_speed_det.sv
// Per-port speed detection at attach.
// Assumes port_conn_i is already synchronous and debounced. On its rising
// edge the line pulled high decides the speed; the flag then holds.
module hubrep_speed_det #(
    parameter int NPORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]   conn_i,
    input  logic [2*NPORT-1:0] rx_i,
    output logic [NPORT-1:0]   ls_o
);
    logic [NPORT-1:0] conn_q;

    // Remembers the previous attach level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) conn_q <= '0;
        else        conn_q <= conn_i;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Latches the speed flag for one port when it attaches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ls_o[p] <= 1'b0;
            else if (conn_i[p] && !conn_q[p])
                ls_o[p] <= (rx_i[2*p+1] == 1'b0) && (rx_i[2*p] == 1'b1);
        end
    end
endmodule

// File: rtl/hubrep_down_route.sv
// Downstream routing: repeats the upstream pair onto enabled ports.
// Assumes us_rx_i is a clean decoded line state. Low-speed ports are driven
// only inside a window opened by a preamble strobe and closed at EOP end.
module hubrep_down_route
    import hubrep_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pair_t              us_rx_i,
    input  logic [NPORT-1:0]   port_en_i,
    input  logic [NPORT-1:0]   port_ls_i,
    input  logic               pre_i,
    input  logic               up_busy_i,
    output logic               busy_o,
    output logic               start_o,
    output logic [2*NPORT-1:0] tx_o,
    output logic [NPORT-1:0]   oe_o
);
    logic               act_q, se0_q, ls_on_q;
    logic               ending, live;
    logic [NPORT-1:0]   oe_n;
    logic [2*NPORT-1:0] tx_n;

    assign start_o = !act_q && !up_busy_i && (us_rx_i == PAIR_K);
    assign ending  = act_q && se0_q && (us_rx_i == PAIR_J);
    assign live    = start_o || act_q;
    assign busy_o  = act_q;

    // Tracks the packet, its EOP and the low-speed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            se0_q   <= 1'b0;
            ls_on_q <= 1'b0;
        end else begin
            if (start_o)     act_q <= 1'b1;
            else if (ending) act_q <= 1'b0;

            if (start_o || ending)                  se0_q <= 1'b0;
            else if (act_q && us_rx_i == PAIR_SE0)  se0_q <= 1'b1;

            if (ending)              ls_on_q <= 1'b0;
            else if (pre_i && act_q) ls_on_q <= 1'b1;
        end
    end

    // Computes per-port enables and the pair in each port's polarity.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            oe_n[p] = live && port_en_i[p] && (!port_ls_i[p] || ls_on_q);
            tx_n[2*p +: 2] = oe_n[p] ? to_logical(us_rx_i, port_ls_i[p])
                                     : idle_of(port_ls_i[p]);
        end
    end

    // Registers the downstream drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o <= '0;
            for (int p = 0; p < NPORT; p++) tx_o[2*p +: 2] <= PAIR_J;
        end else begin
            oe_o <= oe_n;
            tx_o <= tx_n;
        end
    end
endmodule

// File: rtl/hubrep_up_arb.sv
// Upstream path arbitration and repeat.
// Assumes decoded pairs on each port. The lowest-index enabled port showing
// K while the hub is idle takes the path until its own EOP ends.
module hubrep_up_arb
    import hubrep_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int OWN_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NPORT-1:0] rx_i,
    input  logic [NPORT-1:0]   port_en_i,
    input  logic [NPORT-1:0]   port_ls_i,
    input  logic               ds_busy_i,
    input  logic               ds_start_i,
    output logic               busy_o,
    output logic [OWN_W-1:0]   owner_o,
    output pair_t              tx_o,
    output logic               oe_o
);
    pair_t            logical [NPORT];
    logic [NPORT-1:0] claim;
    logic [OWN_W-1:0] pick;
    logic             act_q, se0_q, grab, ending;
    pair_t            own_sym, live_sym;

    // Interprets each port in full-speed polarity and flags claimants.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            logical[p] = to_logical(rx_i[2*p +: 2], port_ls_i[p]);
            claim[p]   = port_en_i[p] && (logical[p] == PAIR_K);
        end
    end

    // Fixed priority: the lowest index wins.
    always_comb begin
        pick = '0;
        for (int i = NPORT - 1; i >= 0; i--)
            if (claim[i]) pick = OWN_W'(i);
    end

    assign grab     = !act_q && !ds_busy_i && !ds_start_i && (|claim);
    assign own_sym  = logical[owner_o];
    assign ending   = act_q && se0_q && (own_sym == PAIR_J);
    assign live_sym = grab ? logical[pick] : own_sym;
    assign busy_o   = act_q;

    // Holds ownership and the owner's EOP progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            se0_q   <= 1'b0;
            owner_o <= '0;
        end else begin
            if (grab) begin
                act_q   <= 1'b1;
                owner_o <= pick;
            end else if (ending) begin
                act_q <= 1'b0;
            end

            if (grab || ending)                     se0_q <= 1'b0;
            else if (act_q && own_sym == PAIR_SE0)  se0_q <= 1'b1;
        end
    end

    // Registers the upstream drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o <= 1'b0;
            tx_o <= PAIR_J;
        end else begin
            oe_o <= grab || act_q;
            tx_o <= (grab || act_q) ? live_sym : PAIR_J;
        end
    end
endmodule

// File: rtl/hubrep_frame_tmr.sv
// Frame timer on the bit-rate tick.
// Assumes bit_tick_i pulses once per full-speed bit. SOF clears the count;
// a marker pulse flags the point EOF2_LEAD bits before the wrap.
module hubrep_frame_tmr #(
    parameter int FRAME_BITS = 12000,
    parameter int EOF2_LEAD  = 10,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sof_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             eof2_o
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] PRE_MARK = CNT_W'(FRAME_BITS - EOF2_LEAD - 1);

    // Counts bit times, clears on SOF and raises the marker pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            eof2_o <= 1'b0;
        end else begin
            eof2_o <= tick_i && !sof_i && (cnt_o == PRE_MARK);
            if (sof_i)
                cnt_o <= '0;
            else if (tick_i)
                cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/hub_repeater_core.sv
// Hub repeater routing core: speed detection, downstream repeat with
// low-speed gating, upstream arbitration and the frame timer.
// Assumes decoded line states and PID strobes from the serial engine.
module hub_repeater_core
    import hubrep_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int FRAME_BITS = 12000,
    parameter int EOF2_LEAD  = 10,
    localparam int OWN_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         us_rx_i,
    output logic [1:0]         us_tx_o,
    output logic               us_oe_o,
    input  logic [2*NPORT-1:0] dn_rx_i,
    output logic [2*NPORT-1:0] dn_tx_o,
    output logic [NPORT-1:0]   dn_oe_o,
    input  logic [NPORT-1:0]   port_en_i,
    input  logic [NPORT-1:0]   port_conn_i,
    input  logic               pre_pid_i,
    input  logic               sof_pid_i,
    input  logic               bit_tick_i,
    output logic [NPORT-1:0]   port_ls_o,
    output logic [OWN_W-1:0]   owner_o,
    output logic [CNT_W-1:0]   frame_cnt_o,
    output logic               eof2_o
);
    logic ds_busy, ds_start, up_busy;

    hubrep_speed_det #(.NPORT(NPORT)) u_speed (
        .clk(clk), .rst_n(rst_n), .conn_i(port_conn_i),
        .rx_i(dn_rx_i), .ls_o(port_ls_o)
    );

    hubrep_down_route #(.NPORT(NPORT)) u_down (
        .clk(clk), .rst_n(rst_n), .us_rx_i(us_rx_i),
        .port_en_i(port_en_i), .port_ls_i(port_ls_o), .pre_i(pre_pid_i),
        .up_busy_i(up_busy), .busy_o(ds_busy), .start_o(ds_start),
        .tx_o(dn_tx_o), .oe_o(dn_oe_o)
    );

    hubrep_up_arb #(.NPORT(NPORT)) u_up (
        .clk(clk), .rst_n(rst_n), .rx_i(dn_rx_i), .port_en_i(port_en_i),
        .port_ls_i(port_ls_o), .ds_busy_i(ds_busy), .ds_start_i(ds_start),
        .busy_o(up_busy), .owner_o(owner_o), .tx_o(us_tx_o), .oe_o(us_oe_o)
    );

    hubrep_frame_tmr #(.FRAME_BITS(FRAME_BITS), .EOF2_LEAD(EOF2_LEAD)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(bit_tick_i), .sof_i(sof_pid_i),
        .cnt_o(frame_cnt_o), .eof2_o(eof2_o)
    );
endmodule

// File: rtl/hubrep_checker.sv
// Temporal checks on the hub repeater core, attached by bind.
module hubrep_checker #(
    parameter int NPORT      = 4,
    parameter int FRAME_BITS = 12000,
    parameter int EOF2_LEAD  = 10,
    localparam int OWN_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               us_oe_o,
    input logic [NPORT-1:0]   dn_oe_o,
    input logic [2*NPORT-1:0] dn_tx_o,
    input logic [NPORT-1:0]   port_en_i,
    input logic [NPORT-1:0]   port_ls_o,
    input logic [OWN_W-1:0]   owner_o,
    input logic [CNT_W-1:0]   frame_cnt_o,
    input logic               eof2_o,
    input logic               sof_pid_i,
    input logic               ls_win_i
);
    // R9: never both directions at once
    a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(us_oe_o && (|dn_oe_o)));

    // R7: the owner that takes the path was enabled
    a_r7_owner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(us_oe_o) |-> (|($past(port_en_i) & (NPORT'(1) << owner_o))));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // R6: undriven port rests at its own idle level
        a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            (!dn_oe_o[p] && $stable(port_ls_o[p])) |->
            (dn_tx_o[2*p +: 2] == (port_ls_o[p] ? 2'b01 : 2'b10)));

        // R2: disabled port is never driven
        a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(port_en_i[p]) |-> !dn_oe_o[p]);

        // R4: low-speed port driven only inside the preamble window
        a_r4_ls_window: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_oe_o[p] && port_ls_o[p] && $stable(port_ls_o[p])) |-> $past(ls_win_i));
    end

    // R10: counter stays within the frame
    a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt_o < CNT_W'(FRAME_BITS));

    // R11: SOF clears the counter
    a_r11_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sof_pid_i) |-> (frame_cnt_o == '0));

    // R12: marker only at its position
    a_r12_eof2_place: assert property (@(posedge clk) disable iff (!rst_n)
        eof2_o |-> (frame_cnt_o == CNT_W'(FRAME_BITS - EOF2_LEAD)));

    // R12: marker is a single-cycle pulse
    a_r12_eof2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eof2_o |=> !eof2_o);
endmodule

bind hub_repeater_core hubrep_checker #(
    .NPORT(NPORT), .FRAME_BITS(FRAME_BITS), .EOF2_LEAD(EOF2_LEAD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .us_oe_o(us_oe_o), .dn_oe_o(dn_oe_o),
    .dn_tx_o(dn_tx_o), .port_en_i(port_en_i), .port_ls_o(port_ls_o),
    .owner_o(owner_o), .frame_cnt_o(frame_cnt_o), .eof2_o(eof2_o),
    .sof_pid_i(sof_pid_i), .ls_win_i(u_down.ls_on_q)
);

// File: tb/sim_hub_repeater_core.sv
// Scoreboard bench: drive tasks queue expectations, a monitor compares.
module sim_hub_repeater_core;
    import hubrep_pkg::*;

    localparam int NP = 4;

    typedef struct packed {
        logic        chk_io;
        logic [3:0]  oe;
        logic [7:0]  dtx;
        logic        uoe;
        logic [1:0]  utx;
        logic [1:0]  own;
        logic        chk_frm;
        logic [13:0] cnt;
        logic        eof2;
        logic        chk_ls;
        logic [3:0]  ls;
        logic [31:0] due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  us_rx = PAIR_J;
    logic [1:0]  us_tx;
    logic        us_oe;
    logic [7:0]  dn_rx = 8'b10_10_10_10;
    logic [7:0]  dn_tx;
    logic [3:0]  dn_oe;
    logic [3:0]  en = 4'b0000;
    logic [3:0]  conn = 4'b0000;
    logic        pre = 1'b0;
    logic        sof = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  ls;
    logic [1:0]  owner;
    logic [13:0] fcnt;
    logic        eof2;

    logic [31:0] cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;
    logic [3:0]  tb_ls = 4'b0000;
    exp_t        exp_q [$];
    string       tag_q [$];
    exp_t        e;
    string       t;

    hub_repeater_core u0 (
        .clk(clk), .rst_n(rst_n), .us_rx_i(us_rx), .us_tx_o(us_tx),
        .us_oe_o(us_oe), .dn_rx_i(dn_rx), .dn_tx_o(dn_tx), .dn_oe_o(dn_oe),
        .port_en_i(en), .port_conn_i(conn), .pre_pid_i(pre),
        .sof_pid_i(sof), .bit_tick_i(tick), .port_ls_o(ls),
        .owner_o(owner), .frame_cnt_o(fcnt), .eof2_o(eof2)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] on_wire(input logic [1:0] sym, input logic l);
        return l ? {sym[0], sym[1]} : sym;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Queues an expectation on the drive outputs for the next edge.
    task automatic exp_io(input string tag, input logic [3:0] oe, input logic [1:0] sym,
                          input logic uoe, input logic [1:0] utx, input logic [1:0] own);
        exp_t x;
        x = '0;
        x.chk_io = 1'b1;
        x.oe = oe;
        for (int p = 0; p < NP; p++)
            x.dtx[2*p +: 2] = oe[p] ? on_wire(sym, tb_ls[p]) : (tb_ls[p] ? 2'b01 : 2'b10);
        x.uoe = uoe;
        x.utx = utx;
        x.own = own;
        x.due = cyc + 1;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic exp_frm(input string tag, input logic [13:0] c, input logic m);
        exp_t x;
        x = '0;
        x.chk_frm = 1'b1;
        x.cnt = c;
        x.eof2 = m;
        x.due = cyc + 1;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic exp_ls(input string tag, input logic [3:0] v);
        exp_t x;
        x = '0;
        x.chk_ls = 1'b1;
        x.ls = v;
        x.due = cyc + 1;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops due expectations and compares them.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (e.chk_io && (dn_oe !== e.oe || dn_tx !== e.dtx || us_oe !== e.uoe ||
                             us_tx !== e.utx || owner !== e.own)) begin
                errors++;
                $display("FAIL %s: actual oe=%b tx=%b uoe=%b utx=%b own=%0d expected oe=%b tx=%b uoe=%b utx=%b own=%0d",
                         t, dn_oe, dn_tx, us_oe, us_tx, owner, e.oe, e.dtx, e.uoe, e.utx, e.own);
            end
            if (e.chk_frm && (fcnt !== e.cnt || eof2 !== e.eof2)) begin
                errors++;
                $display("FAIL %s: actual cnt=%0d eof2=%b expected cnt=%0d eof2=%b",
                         t, fcnt, eof2, e.cnt, e.eof2);
            end
            if (e.chk_ls && ls !== e.ls) begin
                errors++;
                $display("FAIL %s: actual ls=%b expected ls=%b", t, ls, e.ls);
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R13 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R13: reset state
        exp_io("R13 reset drive state", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd0);
        step();
        exp_frm("R13 reset counter", 14'd0, 1'b0);
        exp_ls("R13 reset speed", 4'b0000);
        step();

        // R1: attach, port 2 low speed (D- high), others full speed
        dn_rx = 8'b10_01_10_10;
        conn  = 4'b1111;
        exp_ls("R1 speed at attach", 4'b0100);
        step();
        tb_ls = 4'b0100;
        en = 4'b0111;
        exp_io("R6 idle levels per speed", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd0);
        step();

        // R2 R3 R4: plain downstream packet
        us_rx = PAIR_K;   exp_io("R2 start to full-speed ports", 4'b0011, PAIR_K, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_J;   exp_io("R4 low-speed port silent", 4'b0011, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_K;   exp_io("R2 repeat K", 4'b0011, PAIR_K, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_SE0; exp_io("R3 SE0 repeated", 4'b0011, PAIR_SE0, 1'b0, PAIR_J, 2'd0); step();
        exp_io("R3 second SE0", 4'b0011, PAIR_SE0, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_J;   exp_io("R3 EOP J still driven", 4'b0011, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        exp_io("R3 released after EOP", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd0); step();

        // R5: preamble-prefixed packet
        us_rx = PAIR_K; exp_io("R5 before strobe", 4'b0011, PAIR_K, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_J; pre = 1'b1;
        exp_io("R5 strobe cycle", 4'b0011, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        pre = 1'b0;
        exp_io("R5 low-speed on second clock", 4'b0111, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_K;   exp_io("R6 swapped K on low-speed", 4'b0111, PAIR_K, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_SE0; exp_io("R5 SE0 to all", 4'b0111, PAIR_SE0, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_J;   exp_io("R5 EOP J on low-speed", 4'b0111, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        exp_io("R5 window closed", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_K;   exp_io("R5 next packet gated", 4'b0011, PAIR_K, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_SE0; exp_io("R4 gated SE0", 4'b0011, PAIR_SE0, 1'b0, PAIR_J, 2'd0); step();
        us_rx = PAIR_J;   exp_io("R3 gated EOP J", 4'b0011, PAIR_J, 1'b0, PAIR_J, 2'd0); step();
        exp_io("R3 idle", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd0); step();

        // R7 R8: upstream claims; p1 K, p2 low-speed wire 10 (K), p3 disabled K
        dn_rx = 8'b01_10_01_10;
        exp_io("R7 lowest index wins", 4'b0000, PAIR_J, 1'b1, PAIR_K, 2'd1); step();
        dn_rx[3:2] = PAIR_J; us_rx = PAIR_K;
        exp_io("R9 upstream K ignored while busy", 4'b0000, PAIR_J, 1'b1, PAIR_J, 2'd1); step();
        us_rx = PAIR_J; dn_rx[3:2] = PAIR_SE0;
        exp_io("R8 owner SE0", 4'b0000, PAIR_J, 1'b1, PAIR_SE0, 2'd1); step();
        dn_rx[3:2] = PAIR_J;
        exp_io("R8 owner EOP J", 4'b0000, PAIR_J, 1'b1, PAIR_J, 2'd1); step();
        exp_io("R7 low-speed port claims after release", 4'b0000, PAIR_J, 1'b1, PAIR_K, 2'd2); step();
        dn_rx[5:4] = PAIR_SE0;
        exp_io("R8 low-speed SE0", 4'b0000, PAIR_J, 1'b1, PAIR_SE0, 2'd2); step();
        dn_rx[5:4] = 2'b01;
        exp_io("R6 low-speed J interpreted", 4'b0000, PAIR_J, 1'b1, PAIR_J, 2'd2); step();
        exp_io("R7 disabled port ignored", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd2); step();
        dn_rx[7:6] = PAIR_J;

        // R9: simultaneous start, downstream wins
        us_rx = PAIR_K; dn_rx[1:0] = PAIR_K;
        exp_io("R9 downstream wins tie", 4'b0011, PAIR_K, 1'b0, PAIR_J, 2'd2); step();
        us_rx = PAIR_SE0; dn_rx[1:0] = PAIR_J;
        exp_io("R9 packet continues", 4'b0011, PAIR_SE0, 1'b0, PAIR_J, 2'd2); step();
        us_rx = PAIR_J;
        exp_io("R3 tie packet EOP", 4'b0011, PAIR_J, 1'b0, PAIR_J, 2'd2); step();
        exp_io("R3 tie packet idle", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd2); step();

        // R1: detach and reattach port 3 as low speed; flag holds otherwise
        conn[3] = 1'b0; dn_rx[7:6] = 2'b01;
        exp_ls("R1 flag holds on detach", 4'b0100); step();
        conn[3] = 1'b1;
        exp_ls("R1 reattach low speed", 4'b1100); step();
        tb_ls = 4'b1100;
        dn_rx[7:6] = PAIR_J;
        exp_io("R6 new idle level port 3", 4'b0000, PAIR_J, 1'b0, PAIR_J, 2'd2); step();
        exp_ls("R1 flag holds on line change", 4'b1100); step();

        // R10 R11 R12: frame timer
        tick = 1'b1; sof = 1'b1;
        exp_frm("R11 SOF beats tick", 14'd0, 1'b0); step();
        sof = 1'b0;
        for (int k = 1; k <= 5; k++) step();
        exp_frm("R10 counts ticks", 14'd6, 1'b0); step();
        tick = 1'b0;
        exp_frm("R10 holds without tick", 14'd6, 1'b0); step();
        step();
        tick = 1'b1; sof = 1'b1;
        exp_frm("R11 SOF mid frame", 14'd0, 1'b0); step();
        sof = 1'b0;
        for (int k = 1; k <= 12000; k++) begin
            if (k == 11989) exp_frm("R12 before marker", 14'd11989, 1'b0);
            if (k == 11990) exp_frm("R12 marker", 14'd11990, 1'b1);
            if (k == 11991) exp_frm("R12 marker one cycle", 14'd11991, 1'b0);
            if (k == 11999) exp_frm("R10 last count", 14'd11999, 1'b0);
            if (k == 12000) exp_frm("R10 wrap", 14'd0, 1'b0);
            step();
        end
        tick = 1'b0;
        repeat (3) step();
        done = 1'b1;
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R13 scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule